// File: doc/BRIEF.md
# Radio Transceiver Interrupt Status Controller

This block gathers the eight event sources of a low-power radio transceiver into one status byte and drives a single active-low interrupt request toward a host microcontroller. Each source is qualified by the enable bits of the resource it belongs to: the transmit data register, the receive FIFO, the wake-up timer, the battery monitor and the external interrupt pin. Each source also has its own clear rule. Some bits are cleared when the host reads the status byte. Some stay set until the host services the resource behind them. One bit simply follows a live pin level.

The host samples `status` in the cycle it asserts `stat_rd`. Clears caused by that read take effect at the following clock edge. An event that arrives in the same cycle as the read takes priority over the clear, so the event is not lost. For two sources, releasing the request line and clearing the status bit happen at different times. A FIFO overflow holds the line low until the FIFO has been emptied. A low-battery condition releases the line on a read, but its bit stays set while the supply is still low.

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `status` is 8'h01 (power-on bit set, every other bit clear) and `irq_n` is low.
- R2: Status bit positions: 0 power-on, 1 wake-up, 2 external, 3 low battery, 4 TX register empty, 5 TX underrun, 6 FIFO threshold, 7 FIFO overflow. A qualified event is visible in `status` one clock after it is sampled. `irq_n` is low whenever any of bits 0, 1, 2, 4, 5 or 6 is set.
- R3: The power-on bit (bit 0) and the wake-up bit (bit 1) are cleared by `stat_rd`. When they clear, `irq_n` is released.
- R4: With `en_txreg` and `en_tx` both high, `ev_tx_empty` sets bit 4. Bit 4 is cleared by `tx_wr`, or by either enable going low.
- R5: `ev_tx_underrun` sets bit 4 and bit 5 together. Bit 5 ignores `tx_wr` and `stat_rd` and keeps `irq_n` low. It clears only when `en_txreg` or `en_tx` goes low.
- R6: With `en_fifo` and `en_rx` both high, `fifo_lvl` sets bit 6. Bit 6 clears on `fifo_rd` once the level has dropped, or when either enable goes low.
- R7: `ev_fifo_ovf` sets bits 6 and 7. `stat_rd` clears bit 7, but `irq_n` stays low until `fifo_empty` is seen, even after bit 6 has cleared.
- R8: With `ext_is_irq` high, bit 2 follows the inverted `ext_n` level with a one-clock delay, and `irq_n` follows bit 2. With `ext_is_irq` low, `ext_n` is ignored.
- R9: With `en_lowbat` high, a high `lowbat_lvl` sets bit 3 and pulls `irq_n` low. `stat_rd` releases `irq_n`, but bit 3 stays set while `lowbat_lvl` is high. A read made after the level has dropped clears bit 3.
- R10: Events whose qualifying enables are low leave `status` and `irq_n` unchanged.
- R11: `status` during a `stat_rd` cycle shows the bits as they were before the read. A wake-up event in the same cycle as a read stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_txreg | input | 1 | Internal TX data register enabled |
| en_tx | input | 1 | Transmitter enabled |
| en_fifo | input | 1 | RX FIFO mode enabled |
| en_rx | input | 1 | Receiver enabled |
| en_wkup | input | 1 | Wake-up timer enabled |
| en_lowbat | input | 1 | Low-battery detector enabled |
| ext_is_irq | input | 1 | External pin configured as interrupt input |
| ev_tx_empty | input | 1 | Pulse: TX register became empty |
| ev_tx_underrun | input | 1 | Pulse: byte finished before the next register write |
| fifo_lvl | input | 1 | Level: FIFO fill has reached its threshold |
| ev_fifo_ovf | input | 1 | Pulse: FIFO overflowed |
| ev_wkup | input | 1 | Pulse: wake-up time elapsed |
| lowbat_lvl | input | 1 | Level: supply below battery threshold |
| ext_n | input | 1 | External interrupt pin, active low |
| stat_rd | input | 1 | Status read strobe |
| tx_wr | input | 1 | TX register write strobe |
| fifo_rd | input | 1 | FIFO read strobe |
| fifo_empty | input | 1 | FIFO fully read |
| status | output | 8 | Status byte |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench targets the places where releasing the request line and clearing the status bit come apart. If overflow were tied to its status bit, `irq_n` would be released too early on a read. If the low-battery pin latch were re-armed by the live level, `irq_n` would stay stuck low after a read. The bench also checks that an underrun survives a register write. A design that cleared bit 5 on `tx_wr` would drop the request while the transmitter is still stalled. A read that collides with a wake-up event checks set-over-clear priority; a design with the priority reversed would silently lose the wake-up event.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_txreg,
  input  logic       en_tx,
  input  logic       en_fifo,
  input  logic       en_rx,
  input  logic       en_wkup,
  input  logic       en_lowbat,
  input  logic       ext_is_irq,
  input  logic       ev_tx_empty,
  input  logic       ev_tx_underrun,
  input  logic       fifo_lvl,
  input  logic       ev_fifo_ovf,
  input  logic       ev_wkup,
  input  logic       lowbat_lvl,
  input  logic       ext_n,
  input  logic       stat_rd,
  input  logic       tx_wr,
  input  logic       fifo_rd,
  input  logic       fifo_empty,
  output logic [7:0] status,
  output logic       irq_n
);
  localparam int B_POR = 0, B_WK = 1, B_EXT = 2, B_LB = 3,
                 B_TXE = 4, B_TXU = 5, B_FTH = 6, B_OVF = 7;

  logic por_q, wk_q, ext_q, lb_q, txe_q, txu_q, fth_q, ovf_q;
  logic ovf_pin_q, lb_pin_q, lb_prev_q;

  wire tx_on = en_txreg & en_tx;
  wire rx_on = en_fifo & en_rx;
  wire lb_now = en_lowbat & lowbat_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      por_q     <= 1'b1;
      wk_q      <= 1'b0;
      ext_q     <= 1'b0;
      lb_q      <= 1'b0;
      txe_q     <= 1'b0;
      txu_q     <= 1'b0;
      fth_q     <= 1'b0;
      ovf_q     <= 1'b0;
      ovf_pin_q <= 1'b0;
      lb_pin_q  <= 1'b0;
      lb_prev_q <= 1'b0;
    end else begin
      por_q     <= por_q & ~stat_rd;
      wk_q      <= en_wkup & (ev_wkup | (wk_q & ~stat_rd));
      ext_q     <= ext_is_irq & ~ext_n;
      lb_q      <= en_lowbat & (lowbat_lvl | (lb_q & ~stat_rd));
      lb_prev_q <= lb_now;
      lb_pin_q  <= en_lowbat & ((lb_now & ~lb_prev_q) | (lb_pin_q & ~stat_rd));
      txe_q     <= tx_on & (ev_tx_empty | ev_tx_underrun | (txe_q & ~tx_wr));
      txu_q     <= tx_on & (ev_tx_underrun | txu_q);
      fth_q     <= rx_on & (fifo_lvl | ev_fifo_ovf | (fth_q & ~fifo_rd));
      ovf_q     <= rx_on & (ev_fifo_ovf | (ovf_q & ~stat_rd));
      ovf_pin_q <= rx_on & (ev_fifo_ovf | (ovf_pin_q & ~fifo_empty));
    end
  end

  assign status = {ovf_q, fth_q, txu_q, txe_q, lb_q, ext_q, wk_q, por_q};
  assign irq_n  = ~(por_q | wk_q | ext_q | lb_pin_q | txe_q | txu_q | fth_q | ovf_pin_q);

  a_r2_pin_tracks_bits: assert property (@(posedge clk) disable iff (rst)
    (status[B_POR] | status[B_WK] | status[B_EXT] | status[B_TXE] | status[B_TXU] | status[B_FTH]) |-> !irq_n);
  a_r3_por_read_clears: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> !status[B_POR]);
  a_r5_tx_off_clears: assert property (@(posedge clk) disable iff (rst)
    !(en_txreg && en_tx) |=> !status[B_TXE] && !status[B_TXU]);
  a_r6_rx_off_clears: assert property (@(posedge clk) disable iff (rst)
    !(en_fifo && en_rx) |=> !status[B_FTH] && !status[B_OVF]);
  a_r8_ext_unconfigured: assert property (@(posedge clk) disable iff (rst)
    !ext_is_irq |=> !status[B_EXT]);
  a_r9_lowbat_persists: assert property (@(posedge clk) disable iff (rst)
    (en_lowbat && lowbat_lvl) |=> status[B_LB]);
  a_r11_set_beats_read: assert property (@(posedge clk) disable iff (rst)
    (en_wkup && ev_wkup && stat_rd) |=> status[B_WK]);
endmodule

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_txreg = 0, en_tx = 0, en_fifo = 0, en_rx = 0, en_wkup = 0, en_lowbat = 0, ext_is_irq = 0;
  logic ev_tx_empty = 0, ev_tx_underrun = 0, fifo_lvl = 0, ev_fifo_ovf = 0, ev_wkup = 0, lowbat_lvl = 0;
  logic ext_n = 1, stat_rd = 0, tx_wr = 0, fifo_rd = 0, fifo_empty = 0;
  logic [7:0] status;
  logic irq_n;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst(rst), .en_txreg(en_txreg), .en_tx(en_tx), .en_fifo(en_fifo), .en_rx(en_rx),
    .en_wkup(en_wkup), .en_lowbat(en_lowbat), .ext_is_irq(ext_is_irq), .ev_tx_empty(ev_tx_empty),
    .ev_tx_underrun(ev_tx_underrun), .fifo_lvl(fifo_lvl), .ev_fifo_ovf(ev_fifo_ovf), .ev_wkup(ev_wkup),
    .lowbat_lvl(lowbat_lvl), .ext_n(ext_n), .stat_rd(stat_rd), .tx_wr(tx_wr), .fifo_rd(fifo_rd),
    .fifo_empty(fifo_empty), .status(status), .irq_n(irq_n));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] exp_st, input logic exp_irq);
    n_chk++;
    if (status !== exp_st || irq_n !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: status=%h irq_n=%b expected status=%h irq_n=%b", req, status, irq_n, exp_st, exp_irq);
    end
  endtask

  task automatic read_status();
    stat_rd = 1; step(); stat_rd = 0;
  endtask

  task automatic t_reset();
    step(); step();
    chk("R1 in reset", 8'h01, 1'b0);
    rst = 0; step();
    chk("R1 after reset", 8'h01, 1'b0);
  endtask

  task automatic t_por_read();
    read_status();
    chk("R3 por cleared by read", 8'h00, 1'b1);
  endtask

  task automatic t_wakeup();
    en_wkup = 1;
    ev_wkup = 1; step(); ev_wkup = 0;
    chk("R2 wake-up bit 1", 8'h02, 1'b0);
    stat_rd = 1;
    #1 chk("R11 snapshot during read", 8'h02, 1'b0);
    ev_wkup = 1; step(); ev_wkup = 0; stat_rd = 0;
    chk("R11 event in read cycle kept", 8'h02, 1'b0);
    read_status();
    chk("R3 wake-up cleared by read", 8'h00, 1'b1);
    en_wkup = 0;
  endtask

  task automatic t_gating();
    ev_wkup = 1; lowbat_lvl = 1; ev_tx_empty = 1; ev_tx_underrun = 1; fifo_lvl = 1; ev_fifo_ovf = 1; ext_n = 0;
    step();
    ev_wkup = 0; ev_tx_empty = 0; ev_tx_underrun = 0; ev_fifo_ovf = 0;
    step();
    chk("R10 disabled sources ignored", 8'h00, 1'b1);
    lowbat_lvl = 0; fifo_lvl = 0; ext_n = 1;
  endtask

  task automatic t_txreg();
    en_txreg = 1; en_tx = 1;
    ev_tx_empty = 1; step(); ev_tx_empty = 0;
    chk("R4 tx empty set", 8'h10, 1'b0);
    tx_wr = 1; step(); tx_wr = 0;
    chk("R4 tx write clears", 8'h00, 1'b1);
    ev_tx_empty = 1; step(); ev_tx_empty = 0;
    en_tx = 0; step();
    chk("R4 tx off clears", 8'h00, 1'b1);
    en_tx = 1;
  endtask

  task automatic t_underrun();
    ev_tx_underrun = 1; step(); ev_tx_underrun = 0;
    chk("R5 underrun sets bits 4 and 5", 8'h30, 1'b0);
    tx_wr = 1; step(); tx_wr = 0;
    chk("R5 write leaves underrun", 8'h20, 1'b0);
    read_status();
    chk("R5 read leaves underrun", 8'h20, 1'b0);
    en_txreg = 0; step();
    chk("R5 latch off clears", 8'h00, 1'b1);
    en_tx = 0;
  endtask

  task automatic t_fifo();
    en_fifo = 1; en_rx = 1;
    fifo_lvl = 1; step();
    chk("R6 threshold set", 8'h40, 1'b0);
    fifo_rd = 1; step(); fifo_rd = 0;
    chk("R6 read with level held", 8'h40, 1'b0);
    fifo_lvl = 0; fifo_rd = 1; step(); fifo_rd = 0;
    chk("R6 read after level drop", 8'h00, 1'b1);
    fifo_lvl = 1; step(); en_rx = 0; step(); fifo_lvl = 0;
    chk("R6 receiver off clears", 8'h00, 1'b1);
    en_rx = 1;
  endtask

  task automatic t_overflow();
    ev_fifo_ovf = 1; step(); ev_fifo_ovf = 0;
    chk("R7 overflow sets bits 6 and 7", 8'hC0, 1'b0);
    read_status();
    chk("R7 read clears bit 7 only", 8'h40, 1'b0);
    fifo_rd = 1; step(); fifo_rd = 0;
    chk("R7 line held until empty", 8'h00, 1'b0);
    fifo_empty = 1; step(); fifo_empty = 0;
    chk("R7 empty releases line", 8'h00, 1'b1);
    en_fifo = 0; en_rx = 0;
  endtask

  task automatic t_ext();
    ext_is_irq = 1; ext_n = 0; step();
    chk("R8 ext follows low pin", 8'h04, 1'b0);
    ext_n = 1; step();
    chk("R8 ext follows high pin", 8'h00, 1'b1);
    ext_is_irq = 0; ext_n = 0; step();
    chk("R8 unconfigured pin ignored", 8'h00, 1'b1);
    ext_n = 1;
  endtask

  task automatic t_lowbat();
    en_lowbat = 1; lowbat_lvl = 1; step();
    chk("R9 low battery set", 8'h08, 1'b0);
    read_status();
    chk("R9 read releases line, bit stays", 8'h08, 1'b1);
    step();
    chk("R9 no re-arm while level held", 8'h08, 1'b1);
    lowbat_lvl = 0; step();
    chk("R9 bit held after recovery", 8'h08, 1'b1);
    read_status();
    chk("R9 read after recovery clears", 8'h00, 1'b1);
    en_lowbat = 0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_por_read();
    t_wakeup();
    t_gating();
    t_txreg();
    t_underrun();
    t_fifo();
    t_overflow();
    t_ext();
    t_lowbat();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule